// File: doc/BRIEF.md
# Three-Wire Control Bus Target

This block is the target end of a slow serial control bus made of three wires: an active-low select, a bus clock driven by the host, and one shared data line. It sits inside a chip beside a small register file. The bus wires are asynchronous to the system clock, so they are first resynchronised into the system domain. All framing and shifting then runs on the system clock, and each bus clock edge appears there as a one-cycle rising-edge event.

A frame opens with a 9-bit header. The header holds a 3-bit device address, a read flag and a 5-bit register index. A 16-bit data word follows. On a write, the host shifts the word in, and a single write strobe with the word goes to the register file after the last bit. On a read, the block issues a read strobe as soon as the header is complete and loads the returned value. It then shifts that value out on the data line and drives the line's output-enable for the rest of the frame. Only one of the eight device addresses is answered. That address is set by a parameter.

Top module: `tw_ctl_slave`

## Requirements
- R1: After reset, `bus_dat_oe`, `reg_rd_stb` and `reg_wr_stb` are all low.
- R2: `bus_dat_oe` is low in every cycle in which `bus_sel_n` is high. Raising select in the middle of a frame discards it, and the next low period of select starts with a fresh 9-bit header.
- R3: Bits are taken only on a rising edge of `bus_clk` while select is low, most significant bit first. Header bit 8..6 is the device address, bit 5 is the read flag (1 = read, 0 = write), and bits 4..0 are the register index.
- R4: A write frame to the local address produces one write strobe. During that strobe `reg_idx` holds the header's register index and `reg_wdata` holds the 16 data bits, with the first bit received as bit 15.
- R5: A write frame commits only after its 16th data bit. A write cut short by select going high produces no write strobe.
- R6: A read frame to the local address raises `reg_rd_stb` once, after the header completes and before the first data bit is due. `reg_idx` is valid during the strobe, and `reg_rdata` is taken in that cycle.
- R7: In a read frame, each rising bus clock edge in the data phase presents the next bit of the fetched word on `bus_dat_out`, starting with bit 15. The value holds between edges. `bus_dat_oe` stays high from the end of the header through the last bit, until the next bus clock rise or until select goes high.
- R8: When the header address differs from the local address, the block issues no strobe and never drives the data line for the rest of that frame.
- R9: After a frame's 16 data bits, the next 9 bits under the same select low period are decoded as a new header.
- R10: Each strobe lasts exactly one system clock cycle per frame, and a read strobe and a write strobe never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel_n | input | 1 | Bus select, active low, asynchronous |
| bus_clk | input | 1 | Bus clock from the host, asynchronous |
| bus_dat_in | input | 1 | Data line as seen at the pad input |
| bus_dat_out | output | 1 | Value driven on the data line during reads |
| bus_dat_oe | output | 1 | Output-enable for the data line pad |
| reg_rd_stb | output | 1 | One-cycle register read request |
| reg_wr_stb | output | 1 | One-cycle register write request |
| reg_idx | output | 5 | Register index for the current access |
| reg_wdata | output | 16 | Write data, valid with `reg_wr_stb` |
| reg_rdata | input | 16 | Read data from the register file, taken while `reg_rd_stb` is high |

## Verification
The bench sweeps every register index with both directions at the local address. It also sends frames to every other address, where a design that compared the wrong header bits would answer foreign frames or ignore its own. A write abandoned after 15 bits catches a commit taken one bit early, which would show up as a spurious strobe. A write followed by a read under one select catches a counter that does not reload for the next header, which would misdecode the second frame. Raising select in the middle of a read checks that the pad is released at once, where a design relying on the slow resynchronised select would keep driving the line for several cycles.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic {
        PH_HDR  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int          WIDTH   = 1,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else begin
                    if (s == 0) begin
                        stage_q[s] <= async_in;
                    end else begin
                        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                    end
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/tw_frame_eng.sv
module tw_frame_eng
    import tw_pkg::*;
#(
    parameter int                DEV_W    = 3,
    parameter int                REG_W    = 5,
    parameter int                DATA_W   = 16,
    parameter logic [DEV_W-1:0]  DEV_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_s,
    input  logic              sclk_s,
    input  logic              sdat_s,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [REG_W-1:0]  idx,
    output logic [DATA_W-1:0] wdata,
    output logic              dout,
    output logic              oe
);
    localparam int HDR_W = DEV_W + 1 + REG_W;
    localparam int MAX_W = (DATA_W > HDR_W) ? DATA_W : HDR_W;
    localparam int CNT_W = $clog2(MAX_W);
    localparam int SH_W  = MAX_W;
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [SH_W-1:0]    sh;
        logic               rd;
        logic               match;
        logic               tail;
        logic               oe;
        logic               dout;
        logic               rd_stb;
        logic               wr_stb;
        logic [REG_W-1:0]   idx;
        logic [DATA_W-1:0]  wdata;
        logic               sclk_prev;
    } eng_t;

    eng_t st_d, st_q;
    logic rise;
    logic [SH_W-1:0]  sh_in;
    logic [HDR_W-1:0] hdr;

    always_comb begin
        st_d           = st_q;
        st_d.rd_stb    = 1'b0;
        st_d.wr_stb    = 1'b0;
        st_d.sclk_prev = sclk_s;
        rise           = sclk_s & ~st_q.sclk_prev;
        sh_in          = {st_q.sh[SH_W-2:0], sdat_s};
        hdr            = sh_in[HDR_W-1:0];

        if (st_q.rd_stb) begin
            st_d.sh = SH_W'(reg_rdata);
        end

        if (sel_n_s) begin
            st_d.phase = PH_HDR;
            st_d.cnt   = HDR_LAST;
            st_d.sh    = '0;
            st_d.rd    = 1'b0;
            st_d.match = 1'b0;
            st_d.tail  = 1'b0;
        end else if (rise) begin
            st_d.tail = 1'b0;
            if (st_q.phase == PH_HDR) begin
                st_d.sh = sh_in;
                if (st_q.cnt == '0) begin
                    st_d.match  = (hdr[HDR_W-1 -: DEV_W] == DEV_ADDR);
                    st_d.rd     = hdr[REG_W];
                    if (hdr[HDR_W-1 -: DEV_W] == DEV_ADDR) begin
                        st_d.idx = hdr[REG_W-1:0];
                    end
                    st_d.rd_stb = (hdr[HDR_W-1 -: DEV_W] == DEV_ADDR) & hdr[REG_W];
                    st_d.phase  = PH_DATA;
                    st_d.cnt    = DATA_LAST;
                    st_d.sh     = '0;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end else begin
                if (st_q.rd) begin
                    st_d.dout = st_q.sh[DATA_W-1];
                    st_d.sh   = {st_q.sh[SH_W-2:0], 1'b0};
                end else begin
                    st_d.sh = sh_in;
                end
                if (st_q.cnt == '0) begin
                    if (!st_q.rd && st_q.match) begin
                        st_d.wr_stb = 1'b1;
                        st_d.wdata  = sh_in[DATA_W-1:0];
                    end
                    st_d.tail  = st_q.rd & st_q.match;
                    st_d.phase = PH_HDR;
                    st_d.cnt   = HDR_LAST;
                    st_d.sh    = '0;
                    st_d.rd    = 1'b0;
                    st_d.match = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end

        st_d.oe = ~sel_n_s &
                  (((st_d.phase == PH_DATA) & st_d.rd & st_d.match) | st_d.tail);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_HDR;
            st_q.cnt   <= HDR_LAST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_stb = st_q.rd_stb;
    assign wr_stb = st_q.wr_stb;
    assign idx    = st_q.idx;
    assign wdata  = st_q.wdata;
    assign dout   = st_q.dout;
    assign oe     = st_q.oe;

    // R10: strobes are single-cycle pulses
    p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rd_stb |=> !st_q.rd_stb);
    p_wr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_stb |=> !st_q.wr_stb);
    // R8: a read strobe only follows a header that matched
    p_rd_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rd_stb |-> st_q.match);
    // R5: a write commits only out of the data phase
    p_wr_after_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_stb |-> ($past(st_q.phase) == PH_DATA));
    // R7: the data-out value changes only after a bus clock rise
    p_dout_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rise) |-> $stable(st_q.dout));
endmodule

// File: rtl/tw_ctl_slave.sv
module tw_ctl_slave #(
    parameter int               DEV_W       = 3,
    parameter int               REG_W       = 5,
    parameter int               DATA_W      = 16,
    parameter int               SYNC_STAGES = 2,
    parameter logic [DEV_W-1:0] DEV_ADDR    = 3'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_n,
    input  logic              bus_clk,
    input  logic              bus_dat_in,
    output logic              bus_dat_out,
    output logic              bus_dat_oe,
    output logic              reg_rd_stb,
    output logic              reg_wr_stb,
    output logic [REG_W-1:0]  reg_idx,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int N_SYNC = 3;

    logic [N_SYNC-1:0] raw_w, sync_w;
    logic              oe_int;

    assign raw_w = {bus_sel_n, bus_clk, bus_dat_in};

    tw_sync #(
        .WIDTH   (N_SYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_w),
        .sync_out (sync_w)
    );

    tw_frame_eng #(
        .DEV_W    (DEV_W),
        .REG_W    (REG_W),
        .DATA_W   (DATA_W),
        .DEV_ADDR (DEV_ADDR)
    ) i_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n_s   (sync_w[2]),
        .sclk_s    (sync_w[1]),
        .sdat_s    (sync_w[0]),
        .reg_rdata (reg_rdata),
        .rd_stb    (reg_rd_stb),
        .wr_stb    (reg_wr_stb),
        .idx       (reg_idx),
        .wdata     (reg_wdata),
        .dout      (bus_dat_out),
        .oe        (oe_int)
    );

    // the raw select releases the pad at once, ahead of the synchroniser
    assign bus_dat_oe = oe_int & ~bus_sel_n;

    // R2: no drive while select is high
    p_oe_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel_n |-> !bus_dat_oe);
    // R10: read and write strobes are exclusive
    p_stb_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_stb && reg_wr_stb));
endmodule

// File: tb/test_tw_ctl_slave.sv
module test_tw_ctl_slave;
    localparam int         CLK_PERIOD = 10;
    localparam logic [2:0] LOC_ADDR   = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel_n = 1'b1;
    logic        bus_clk = 1'b0;
    logic        bus_dat_in = 1'b0;
    logic        bus_dat_out, bus_dat_oe, reg_rd_stb, reg_wr_stb;
    logic [4:0]  reg_idx;
    logic [15:0] reg_wdata, reg_rdata;

    int total = 0, bad = 0;
    int wr_cnt = 0, rd_cnt = 0, oe_hits = 0;
    logic [4:0]  last_idx = '0, rd_idx = '0;
    logic [15:0] last_data = '0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] rval(input logic [4:0] i);
        return 16'((16'(i) * 16'h1357) ^ 16'hC0DE);
    endfunction

    assign reg_rdata = rval(reg_idx);

    tw_ctl_slave #(.DEV_ADDR(LOC_ADDR)) i_tw_ctl_slave (
        .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_clk(bus_clk),
        .bus_dat_in(bus_dat_in), .bus_dat_out(bus_dat_out), .bus_dat_oe(bus_dat_oe),
        .reg_rd_stb(reg_rd_stb), .reg_wr_stb(reg_wr_stb), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr_stb) begin
                wr_cnt    <= wr_cnt + 1;
                last_idx  <= reg_idx;
                last_data <= reg_wdata;
            end
            if (reg_rd_stb) begin
                rd_cnt <= rd_cnt + 1;
                rd_idx <= reg_idx;
            end
            if (bus_dat_oe) oe_hits <= oe_hits + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        bus_dat_in = b;
        tick(2);
        bus_clk = 1'b1;
        tick(4);
        bus_clk = 1'b0;
        tick(2);
    endtask

    task automatic recv_bit(output logic b, output logic e);
        bus_clk = 1'b1;
        tick(4);
        b = bus_dat_out;
        e = bus_dat_oe;
        bus_clk = 1'b0;
        tick(4);
    endtask

    task automatic send_hdr(input logic [2:0] a, input logic rd, input logic [4:0] idx);
        logic [8:0] h;
        h = {a, rd, idx};
        for (int i = 8; i >= 0; i--) send_bit(h[i]);
    endtask

    task automatic wr_body(input logic [2:0] a, input logic [4:0] idx, input logic [15:0] v);
        int w0, o0, r0;
        w0 = wr_cnt; o0 = oe_hits; r0 = rd_cnt;
        send_hdr(a, 1'b0, idx);
        for (int i = 15; i >= 0; i--) send_bit(v[i]);
        tick(4);
        if (a == LOC_ADDR) begin
            chk(wr_cnt == w0 + 1, "R4/R10 write strobe count", wr_cnt - w0, 1);
            chk(last_idx == idx && last_data == v, "R4/R3 write index/data",
                {last_idx, last_data}, {idx, v});
        end else begin
            chk(wr_cnt == w0, "R8 no write on foreign address", wr_cnt - w0, 0);
        end
        chk(oe_hits == o0 && rd_cnt == r0, "R8/R4 no drive or read in write",
            oe_hits - o0, 0);
    endtask

    task automatic rd_body(input logic [2:0] a, input logic [4:0] idx);
        int r0, o0, w0;
        logic [15:0] got;
        logic b, e;
        bit all_oe, any_oe;
        r0 = rd_cnt; o0 = oe_hits; w0 = wr_cnt;
        send_hdr(a, 1'b1, idx);
        if (a == LOC_ADDR) begin
            chk(rd_cnt == r0 + 1 && rd_idx == idx, "R6 read strobe before data",
                rd_cnt - r0, 1);
        end
        all_oe = 1; any_oe = 0;
        for (int i = 15; i >= 0; i--) begin
            recv_bit(b, e);
            got[i] = b;
            all_oe &= e;
            any_oe |= e;
        end
        if (a == LOC_ADDR) begin
            chk(got == rval(idx), "R7 read data MSB first", got, rval(idx));
            chk(all_oe, "R7 output-enable through data", all_oe, 1);
        end else begin
            chk(!any_oe && oe_hits == o0, "R8 no drive on foreign read", oe_hits - o0, 0);
            chk(rd_cnt == r0, "R8 no read strobe on foreign address", rd_cnt - r0, 0);
        end
        chk(wr_cnt == w0, "R10 no write in read frame", wr_cnt - w0, 0);
    endtask

    task automatic sel_lo();
        bus_sel_n = 1'b0;
        tick(4);
    endtask

    task automatic sel_hi();
        bus_sel_n = 1'b1;
        tick(6);
    endtask

    initial begin
        logic b, e;
        int w0;
        tick(3);
        chk(!bus_dat_oe && !reg_rd_stb && !reg_wr_stb, "R1 reset outputs",
            {bus_dat_oe, reg_rd_stb, reg_wr_stb}, 0);
        rst_n = 1'b1;
        tick(3);
        chk(!bus_dat_oe && !reg_rd_stb && !reg_wr_stb, "R1 idle after reset",
            {bus_dat_oe, reg_rd_stb, reg_wr_stb}, 0);

        // R3/R4/R6/R7: every register index, both directions, local address
        for (int r = 0; r < 32; r++) begin
            sel_lo(); wr_body(LOC_ADDR, 5'(r), rval(5'(r)) ^ 16'hA5F0 ^ 16'(r << 7)); sel_hi();
            sel_lo(); rd_body(LOC_ADDR, 5'(r)); sel_hi();
            chk(!bus_dat_oe, "R2 released after select high", bus_dat_oe, 0);
        end

        // R8: every foreign address
        for (int a = 0; a < 8; a++) begin
            if (3'(a) == LOC_ADDR) continue;
            for (int r = 0; r < 32; r += 11) begin
                sel_lo(); wr_body(3'(a), 5'(r), 16'hFFFF); sel_hi();
                sel_lo(); rd_body(3'(a), 5'(r)); sel_hi();
            end
        end

        // R9: write then read under one select
        sel_lo();
        wr_body(LOC_ADDR, 5'd9, 16'h8001);
        rd_body(LOC_ADDR, 5'd22);
        // R7 tail: enable stays up until the next bus clock rise
        chk(bus_dat_oe, "R7 enable held after last bit", bus_dat_oe, 1);
        send_bit(1'b0);
        chk(!bus_dat_oe, "R7 enable dropped at next rise", bus_dat_oe, 0);
        sel_hi();

        // R5: write cut after 15 data bits
        w0 = wr_cnt;
        sel_lo();
        send_hdr(LOC_ADDR, 1'b0, 5'd3);
        for (int i = 0; i < 15; i++) send_bit(1'b1);
        sel_hi();
        tick(4);
        chk(wr_cnt == w0, "R5 no commit on aborted write", wr_cnt - w0, 0);

        // R2: select raised mid-read releases the pad immediately
        sel_lo();
        send_hdr(LOC_ADDR, 1'b1, 5'd17);
        for (int i = 0; i < 5; i++) recv_bit(b, e);
        chk(bus_dat_oe, "R7 enable mid-read", bus_dat_oe, 1);
        bus_sel_n = 1'b1;
        #1;
        chk(!bus_dat_oe, "R2 enable low as select rises", bus_dat_oe, 0);
        tick(6);
        // R2: fresh header after abort
        sel_lo(); wr_body(LOC_ADDR, 5'd30, 16'h1234); sel_hi();

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule